// File: doc/BRIEF.md
# Host-Loadable Output Register Bank

This block holds sixteen single-bit state registers arranged as two byte-wide groups, A (cells 0 to 7) and B (cells 8 to 15). In normal operation each cell is updated by the surrounding programmable logic, which supplies per-cell clear, preset, clock-enable and next-state vectors. The logic array that computes those vectors lies outside the block. Every cell output is always returned as a feedback vector, whether or not the cell drives a pin.

A host processor reaches the bank through a byte-wide port with four locations. Address 0 is the group A cells, address 1 is the group B cells, address 2 is the group A protect mask and address 3 is the group B protect mask. The write strobe is active low and is sampled by the system clock. A host write to a cell group lands only on the bits whose protect-mask bit is 0. On those bits it overrides the internal controls in the cycle in which it lands. This lets software preload counters or shift registers, or use cells as mailboxes, while a mask shields cells that form a running state machine.

The block also forms a per-cell pin output enable. Two parameter vectors configure it. One marks which cells are declared as pins. The other marks which cells have an enable equation.

Top module: `mcell_bank`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, all sixteen cells and both protect masks are 0, and a read of every address returns 00h.
- R2: A host write to address 0 or 1 loads the unmasked bits of group A or group B, respectively. A read of address 0 or 1 returns that group's current cell values.
- R3: A protect-mask bit of 1 blocks host writes to the matching cell, and a bit of 0 allows them. For example, a mask of 0Fh keeps bits 3..0 of the group unchanged and lets bits 7..4 load.
- R4: In the cycle a host load lands, an unmasked cell takes the host data regardless of its clear, preset and enable inputs. Masked cells and cells of the other group follow their internal inputs.
- R5: Host data is taken when the strobe is released (goes from 0 to 1), using the data and address present in the last sampled cycle before the release. Nothing is loaded while the strobe stays low. With inputs changed at a falling clock edge, the new value is visible after the second rising clock edge that follows the release.
- R6: A cell that the host is not loading is cleared when clear is 1. Otherwise it is set when preset is 1. Otherwise it takes next-state when enable is 1. Otherwise it holds.
- R7: Addresses 2 and 3 hold the group A and group B protect masks. Each can be written and read back in full, and neither is affected by its own mask.
- R8: For a cell whose PIN_MASK bit and OE_EQ_MASK bit are both 1, pinOe equals oeTermIn OR dirIn for that cell. The defaults are PIN_MASK = FF7Fh and OE_EQ_MASK = FFBFh.
- R9: A cell declared as a pin but without an enable equation (bit 6 by default) has pinOe fixed at 1 from reset onward. A cell not declared as a pin (bit 7 by default) has pinOe equal to its dirIn bit.
- R10: mcellQ always presents all sixteen cells, group A on bits 7..0 and group B on bits 15..8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| hostAddr | input | 2 | Host location select (0 A cells, 1 B cells, 2 A mask, 3 B mask) |
| hostData | input | 8 | Host write data |
| hostWrN | input | 1 | Active-low host write strobe |
| hostRdData | output | 8 | Read data for the selected location |
| nextIn | input | 16 | Per-cell next-state value |
| presetIn | input | 16 | Per-cell preset request |
| clearIn | input | 16 | Per-cell clear request |
| clkEnIn | input | 16 | Per-cell clocked-update enable |
| oeTermIn | input | 16 | Per-cell enable term from the logic array |
| dirIn | input | 16 | Per-cell direction-register bit |
| mcellQ | output | 16 | Cell values returned as feedback |
| pinOe | output | 16 | Per-cell pin output enable |

## Verification
Host writes use random data, random addresses and random masks, which separates masked bits from unmasked bits and shows whether loads reach the right group. Internal updates are driven with random, sparse clear and preset vectors over dense enables, plus one directed vector where all three controls overlap. This shows whether the priority among clear, preset and next-state is correct. A directed write changes the data while the strobe is low and samples one cycle before and one cycle after the expected landing. This distinguishes capture at release from capture at assertion and exposes any off-by-one latency. A write that lands while clear is asserted everywhere shows whether the host load overrides the internal inputs for unmasked bits only.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  localparam int GRP_W   = 8;
  localparam int NUM_GRP = 2;
  localparam int NCELL   = GRP_W * NUM_GRP;
  localparam int ADDR_W  = $clog2(2 * NUM_GRP);
  localparam int GSEL_W  = ADDR_W - 1;

  typedef struct packed {
    logic [NUM_GRP-1:0] loadData;
    logic [NUM_GRP-1:0] loadMask;
    logic [GRP_W-1:0]   data;
  } hostStrb_t;
endpackage

// File: rtl/mcell_ctrl.sv
module mcell_ctrl
  import mcell_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [GRP_W-1:0]  hostData,
  input  logic              hostWrN,
  output hostStrb_t         strb
);
  logic              wrNQ;
  logic              wrNQ2;
  logic [ADDR_W-1:0] addrQ;
  logic [GRP_W-1:0]  dataQ;
  logic              relPulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrNQ  <= 1'b1;
      wrNQ2 <= 1'b1;
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      wrNQ  <= hostWrN;
      wrNQ2 <= wrNQ;
      if (!hostWrN) begin
        addrQ <= hostAddr;
        dataQ <= hostData;
      end
    end
  end

  assign relPulse = wrNQ & ~wrNQ2;

  always_comb begin
    strb.data = dataQ;
    for (int g = 0; g < NUM_GRP; g++) begin
      strb.loadData[g] = relPulse && !addrQ[ADDR_W-1] &&
                         (addrQ[GSEL_W-1:0] == GSEL_W'(g));
      strb.loadMask[g] = relPulse && addrQ[ADDR_W-1] &&
                         (addrQ[GSEL_W-1:0] == GSEL_W'(g));
    end
  end
endmodule

// File: rtl/mcell_dp.sv
module mcell_dp
  import mcell_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hostStrb_t         strb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [NCELL-1:0]  nextIn,
  input  logic [NCELL-1:0]  presetIn,
  input  logic [NCELL-1:0]  clearIn,
  input  logic [NCELL-1:0]  clkEnIn,
  output logic [NCELL-1:0]  cellFlat,
  output logic [NCELL-1:0]  maskFlat,
  output logic [GRP_W-1:0]  rdData
);
  logic [GRP_W-1:0] cellQ [NUM_GRP];
  logic [GRP_W-1:0] maskQ [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cellQ[g] <= '0;
      end else begin
        for (int b = 0; b < GRP_W; b++) begin
          if (strb.loadData[g] && !maskQ[g][b])
            cellQ[g][b] <= strb.data[b];
          else if (clearIn[g*GRP_W+b])
            cellQ[g][b] <= 1'b0;
          else if (presetIn[g*GRP_W+b])
            cellQ[g][b] <= 1'b1;
          else if (clkEnIn[g*GRP_W+b])
            cellQ[g][b] <= nextIn[g*GRP_W+b];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)
        maskQ[g] <= '0;
      else if (strb.loadMask[g])
        maskQ[g] <= strb.data;
    end

    assign cellFlat[g*GRP_W +: GRP_W] = cellQ[g];
    assign maskFlat[g*GRP_W +: GRP_W] = maskQ[g];
  end

  always_comb begin
    if (rdAddr[ADDR_W-1])
      rdData = maskQ[rdAddr[GSEL_W-1:0]];
    else
      rdData = cellQ[rdAddr[GSEL_W-1:0]];
  end
endmodule

// File: rtl/mcell_bank.sv
module mcell_bank
  import mcell_pkg::*;
#(
  parameter logic [NCELL-1:0] PIN_MASK   = 16'hFF7F,
  parameter logic [NCELL-1:0] OE_EQ_MASK = 16'hFFBF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [GRP_W-1:0]  hostData,
  input  logic              hostWrN,
  output logic [GRP_W-1:0]  hostRdData,
  input  logic [NCELL-1:0]  nextIn,
  input  logic [NCELL-1:0]  presetIn,
  input  logic [NCELL-1:0]  clearIn,
  input  logic [NCELL-1:0]  clkEnIn,
  input  logic [NCELL-1:0]  oeTermIn,
  input  logic [NCELL-1:0]  dirIn,
  output logic [NCELL-1:0]  mcellQ,
  output logic [NCELL-1:0]  pinOe
);
  hostStrb_t        strb;
  logic [NCELL-1:0] maskFlat;

  mcell_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostData(hostData),
    .hostWrN(hostWrN), .strb(strb)
  );

  mcell_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(hostAddr),
    .nextIn(nextIn), .presetIn(presetIn), .clearIn(clearIn),
    .clkEnIn(clkEnIn), .cellFlat(mcellQ), .maskFlat(maskFlat),
    .rdData(hostRdData)
  );

  for (genvar i = 0; i < NCELL; i++) begin : g_oe
    if (PIN_MASK[i] && !OE_EQ_MASK[i]) begin : g_fixed
      assign pinOe[i] = 1'b1;
    end else if (PIN_MASK[i]) begin : g_eq
      assign pinOe[i] = oeTermIn[i] | dirIn[i];
    end else begin : g_node
      assign pinOe[i] = dirIn[i];
    end
  end
endmodule

// File: rtl/mcell_bank_chk.sv
module mcell_bank_chk
  import mcell_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [NCELL-1:0] clearIn,
  input logic [NCELL-1:0] presetIn,
  input logic [NCELL-1:0] clkEnIn,
  input logic [NCELL-1:0] mcellQ,
  input logic [NCELL-1:0] maskFlat,
  input hostStrb_t        strb
);
  AST_RESET_CLEAN: assert property (@(posedge clk) !rstN |=> (mcellQ == '0 && maskFlat == '0)); // R1

  AST_LOAD_GRP_A: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadData[0] |=> (((mcellQ[GRP_W-1:0] ^ $past(strb.data)) & ~$past(maskFlat[GRP_W-1:0])) == '0)); // R4

  AST_LOAD_GRP_B: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadData[1] |=> (((mcellQ[NCELL-1:GRP_W] ^ $past(strb.data)) & ~$past(maskFlat[NCELL-1:GRP_W])) == '0)); // R2

  AST_MASK_PROTECT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadData != '0 && clearIn == '0 && presetIn == '0 && clkEnIn == '0)
    |=> (((mcellQ ^ $past(mcellQ)) & $past(maskFlat)) == '0)); // R3

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadData == '0 && clearIn != '0) |=> ((mcellQ & $past(clearIn)) == '0)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadData == '0 && clearIn == '0 && presetIn == '0 && clkEnIn == '0) |=> $stable(mcellQ)); // R5
endmodule

bind mcell_bank mcell_bank_chk u_chk (
  .clk(clk), .rstN(rstN), .clearIn(clearIn), .presetIn(presetIn),
  .clkEnIn(clkEnIn), .mcellQ(mcellQ), .maskFlat(maskFlat), .strb(strb)
);

// File: tb/mcell_bank_tb.sv
module mcell_bank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  hostAddr = '0;
  logic [7:0]  hostData = '0;
  logic        hostWrN = 1'b1;
  logic [7:0]  hostRdData;
  logic [15:0] nextIn = '0, presetIn = '0, clearIn = '0, clkEnIn = '0;
  logic [15:0] oeTermIn = '0, dirIn = '0;
  logic [15:0] mcellQ, pinOe;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;
  logic [15:0] qExp = '0;
  logic [7:0]  maskExp [2] = '{8'h00, 8'h00};

  always #4 clk = ~clk;

  mcell_bank u_dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostData(hostData),
    .hostWrN(hostWrN), .hostRdData(hostRdData), .nextIn(nextIn),
    .presetIn(presetIn), .clearIn(clearIn), .clkEnIn(clkEnIn),
    .oeTermIn(oeTermIn), .dirIn(dirIn), .mcellQ(mcellQ), .pinOe(pinOe)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] oeModel(logic [15:0] t, logic [15:0] d);
    logic [15:0] r = t | d;
    r[6] = 1'b1;
    r[7] = d[7];
    return r;
  endfunction

  function automatic logic [15:0] stepModel(logic [15:0] q, logic [15:0] nx,
      logic [15:0] pr, logic [15:0] cl, logic [15:0] en);
    logic [15:0] r = q;
    for (int i = 0; i < 16; i++) begin
      if (cl[i]) r[i] = 1'b0;
      else if (pr[i]) r[i] = 1'b1;
      else if (en[i]) r[i] = nx[i];
    end
    return r;
  endfunction

  function automatic logic [15:0] loadModel(logic [15:0] q, int g,
      logic [7:0] d, logic [7:0] m);
    logic [15:0] r = q;
    for (int b = 0; b < 8; b++)
      if (!m[b]) r[g*8+b] = d[b];
    return r;
  endfunction

  task automatic hostWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostData = ~d; hostWrN = 1'b0;
    @(negedge clk);
    hostData = d;
    @(negedge clk);
    hostWrN = 1'b1; hostData = 8'($urandom);
    @(negedge clk);
    @(negedge clk);
    if (a[1]) maskExp[a[0]] = d;
    else qExp = loadModel(qExp, a[0], d, maskExp[a[0]]);
  endtask

  task automatic hostRead(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a;
    #1 d = hostRdData;
  endtask

  task automatic checkAll(string req);
    logic [7:0] rd;
    check({req, " feedback"}, mcellQ, qExp);
    hostRead(2'd0, rd); check({req, " read A"}, {8'h0, rd}, {8'h0, qExp[7:0]});
    hostRead(2'd1, rd); check({req, " read B"}, {8'h0, rd}, {8'h0, qExp[15:8]});
    hostRead(2'd2, rd); check({req, " read mask A R7"}, {8'h0, rd}, {8'h0, maskExp[0]});
    hostRead(2'd3, rd); check({req, " read mask B R7"}, {8'h0, rd}, {8'h0, maskExp[1]});
  endtask

  task automatic internalStep(logic [15:0] nx, logic [15:0] pr,
      logic [15:0] cl, logic [15:0] en, string req);
    @(negedge clk);
    nextIn = nx; presetIn = pr; clearIn = cl; clkEnIn = en;
    @(negedge clk);
    qExp = stepModel(qExp, nx, pr, cl, en);
    check(req, mcellQ, qExp);
    nextIn = '0; presetIn = '0; clearIn = '0; clkEnIn = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R1: held in reset
    check("R1 cells during reset", mcellQ, 16'h0000);
    rstN = 1'b1;
    checkAll("R1 after reset");
    check("R9 pin oe from reset", pinOe, 16'h0040);

    // R2 / R10: basic group loads
    hostWrite(2'd0, 8'hA5);
    checkAll("R2 R10 load A");
    hostWrite(2'd1, 8'h3C);
    checkAll("R2 R10 load B");

    // R3 / R7: mask 0Fh protects the low nibble
    hostWrite(2'd2, 8'h0F);
    hostWrite(2'd0, 8'h5A);
    checkAll("R3 mask 0F on A");
    check("R3 low nibble kept", {8'h0, mcellQ[7:0]}, 16'h0055);

    // R5: capture at release, exact landing cycle
    @(negedge clk);
    hostAddr = 2'd0; hostData = 8'hFF; hostWrN = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 nothing while strobe low", mcellQ, qExp);
    hostData = 8'hC3;
    @(negedge clk);
    hostWrN = 1'b1; hostData = 8'h00;
    @(negedge clk);
    check("R5 not landed after one edge", mcellQ, qExp);
    @(negedge clk);
    qExp = loadModel(qExp, 0, 8'hC3, maskExp[0]);
    check("R5 landed after second edge", mcellQ, qExp);

    // R4: host load beats clear for unmasked bits only
    hostWrite(2'd3, 8'hF0);
    @(negedge clk);
    hostAddr = 2'd1; hostData = 8'h96; hostWrN = 1'b0;
    @(negedge clk);
    hostWrN = 1'b1;
    @(negedge clk);
    clearIn = '1; presetIn = 16'($urandom); clkEnIn = '1; nextIn = 16'($urandom);
    @(negedge clk);
    clearIn = '0; presetIn = '0; clkEnIn = '0; nextIn = '0;
    qExp = {8'h96 & ~maskExp[1], 8'h00};
    check("R4 load over clear", mcellQ, qExp);

    // R6: directed overlap of clear, preset and enable
    internalStep(16'hF0F0, 16'h00FF, 16'h000F, 16'hFFFF, "R6 directed overlap");
    internalStep(16'h0000, 16'h0000, 16'h0000, 16'h0000, "R6 hold");

    // R2 R3 R7: random host traffic
    for (int k = 0; k < 40; k++) begin
      hostWrite(2'($urandom), 8'($urandom));
      check("R2 R3 random write", mcellQ, qExp);
    end
    checkAll("R7 after random traffic");

    // R6: random internal updates
    for (int k = 0; k < 200; k++)
      internalStep(16'($urandom), 16'($urandom & $urandom), 16'($urandom & $urandom & $urandom),
                   16'($urandom | $urandom), "R6 random step");
    checkAll("R10 after random steps");

    // R8 / R9: output enables
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      oeTermIn = 16'($urandom); dirIn = 16'($urandom);
      #1 check("R8 R9 output enable", pinOe, oeModel(oeTermIn, dirIn));
    end
    hostRead(2'd3, rd);
    check("R7 final mask B", {8'h0, rd}, {8'h0, maskExp[1]});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule